// File: doc/BRIEF.md
# Fuse Array Controller with Mirror Window

This block sits between a register bus and a one-time-programmable fuse array. Software sees the array through a window of 32-bit mirror registers, which it can read and overwrite at will. An overwrite touches only the mirror. The fuse array itself changes only when software writes the burn instruction into the command register. A load instruction copies the array back into the mirrors. Both instructions run on their own. Software learns that one has finished by polling the command register until its instruction field reads zero.

The array is modelled as a bank of registers. Burning can only set bits, since each array word is ORed with its mirror. Each word's burn lasts a configurable pulse width in clock cycles. At reset the controller loads the array into the mirrors on its own, and the command register reads busy until that load is done. During every load the controller also rebuilds a secret-region integrity status, one parity bit per word of a fixed secret region. Register data crosses the bus in big-endian byte order.

The sequencer has three states. ST_LOAD copies one word per cycle, and reset enters it directly. ST_IDLE waits for a command. ST_BURN holds each word for the pulse width. The transitions are:
- ST_IDLE to ST_LOAD on an accepted load instruction.
- ST_IDLE to ST_BURN on an accepted burn instruction.
- ST_LOAD to ST_IDLE after the last word.
- ST_BURN to ST_IDLE after the last word's final pulse cycle.

Top module: `fusectl_top`

## Requirements
- R1: After reset the controller copies every array word into its mirror, one word per cycle. The command register reads instruction 0x01 for exactly N_WORDS cycles, counted from the first clock edge after reset, and then reads 0 with the error flag clear. At reset, array word i holds FACTORY_SEED XOR (i * 0x01010107), taken modulo 2^32.
- R2: Bus data is big-endian. Bus byte lane [31:24] carries register bits [7:0], and the other bytes follow the same reversal. This applies to both reads and writes. A read returns data on the clock edge that samples the request.
- R3: Writing instruction 0x01 to the command register (offset 0x20, bits 7:0) while idle reloads all mirrors from the array. The instruction field reads 0x01 for N_WORDS cycles and then reads 0.
- R4: Writing instruction 0x02 while idle ORs each mirror word into its array word, in index order. Each word is held for max(P,1) cycles, where P is the pulse-width field. The controller stays busy for N_WORDS*max(P,1) cycles.
- R5: A write to a mirror word (offset 0x200 + 4*i) changes that mirror word only. The array keeps its value, so a later load restores the mirror.
- R6: The configuration register at offset 0x28 stores the pulse width in bits 15:0. Its bits 31:16 read as zero.
- R7: Any instruction code other than 0x01 or 0x02, written while idle, sets the error flag (command register bit 8) and starts nothing.
- R8: A write to the command register while a command is running sets the error flag. It does not change the running command or its duration.
- R9: An accepted instruction clears the error flag. The flag otherwise keeps its value.
- R10: The status register at offset 0x24 has bit k equal to the XOR of all bits of array word SEC_FIRST+k, for k below SEC_WORDS. It is refreshed on every load and ignores writes.
- R11: Reads of a misaligned address, or of any offset that is not a defined register, return zero. Writes to such addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data, big-endian |
| bus_rdata | output | 32 | Read data, big-endian, registered |

## Verification
The bench compares the busy duration with an arithmetic count in several cases:
- the reset load;
- an explicit load;
- a burn with pulse width 3;
- a burn with pulse width 0;
- a burn that receives a command write while it runs.

Together these cases separate the per-word hold from the pulse-width-zero floor, and show that a write during a command neither restarts nor shortens it. The mirror contents are swept over all words in three situations:
- after reset, against the factory pattern;
- after a load that follows an override, which separates mirror-only writes from array writes;
- after a burn with a distinct per-word pattern, which must show the OR of the old and new contents rather than a replacement.

The parity status is checked twice, once after reset and once after the burn changed the secret words. The error flag is checked after an unknown code, after a write during a busy command, and after a valid instruction.

// File: rtl/fusectl_pkg.sv
package fusectl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_BURN = 2'd2
    } seq_state_t;

    localparam logic [7:0] OP_LOAD = 8'h01;
    localparam logic [7:0] OP_BURN = 8'h02;

    // Reverse byte order between bus lanes and register bits.
    function automatic logic [31:0] swap32(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    // Factory content of array word i.
    function automatic logic [31:0] factory_word(input logic [31:0] seed, input int unsigned i);
        return seed ^ (32'(i) * 32'h0101_0107);
    endfunction

endpackage

// File: rtl/fusectl_regs.sv
module fusectl_regs
    import fusectl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int N_WORDS = 34,
    parameter int IDX_W = 6,
    parameter logic [ADDR_W-1:0] CMD_OFF = 'h20,
    parameter logic [ADDR_W-1:0] HAM_OFF = 'h24,
    parameter logic [ADDR_W-1:0] CFG_OFF = 'h28,
    parameter logic [ADDR_W-1:0] WIN_BASE = 'h200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              busy,
    input  logic [7:0]        op_code,
    input  logic [31:0]       mir_rdata,
    input  logic [31:0]       ham_status,
    output logic              start_load,
    output logic              start_burn,
    output logic              err_flag,
    output logic [15:0]       pulse_w,
    output logic              mir_we,
    output logic [IDX_W-1:0]  mir_idx,
    output logic [31:0]       mir_wdata
);

    localparam int WA_W = ADDR_W - 2;
    localparam logic [WA_W-1:0] CMD_WA = CMD_OFF[ADDR_W-1:2];
    localparam logic [WA_W-1:0] HAM_WA = HAM_OFF[ADDR_W-1:2];
    localparam logic [WA_W-1:0] CFG_WA = CFG_OFF[ADDR_W-1:2];
    localparam logic [WA_W-1:0] WIN_WA = WIN_BASE[ADDR_W-1:2];
    localparam logic [WA_W-1:0] WIN_LEN = WA_W'(N_WORDS);

    logic [WA_W-1:0] wa;
    logic [WA_W-1:0] win_off;
    logic            aligned;
    logic            hit_cmd, hit_ham, hit_cfg, hit_win;
    logic [31:0]     wdata_int;
    logic            cmd_wr;
    logic            code_ok;
    logic [31:0]     rd_val;
    logic            err_q;
    logic [15:0]     pw_q;
    logic [31:0]     rdata_q;

    assign wa        = bus_addr[ADDR_W-1:2];
    assign aligned   = (bus_addr[1:0] == 2'b00);
    assign win_off   = wa - WIN_WA;
    assign hit_cmd   = aligned && (wa == CMD_WA);
    assign hit_ham   = aligned && (wa == HAM_WA);
    assign hit_cfg   = aligned && (wa == CFG_WA);
    assign hit_win   = aligned && (wa >= WIN_WA) && (win_off < WIN_LEN);
    assign wdata_int = swap32(bus_wdata);

    assign cmd_wr     = bus_valid && bus_write && hit_cmd;
    assign code_ok    = (wdata_int[7:0] == OP_LOAD) || (wdata_int[7:0] == OP_BURN);
    assign start_load = cmd_wr && !busy && (wdata_int[7:0] == OP_LOAD);
    assign start_burn = cmd_wr && !busy && (wdata_int[7:0] == OP_BURN);

    assign mir_we    = bus_valid && bus_write && hit_win;
    assign mir_idx   = win_off[IDX_W-1:0];
    assign mir_wdata = wdata_int;

    // Error flag and pulse-width configuration.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
            pw_q  <= '0;
        end else begin
            if (cmd_wr) begin
                err_q <= busy || !code_ok;
            end
            if (bus_valid && bus_write && hit_cfg) begin
                pw_q <= wdata_int[15:0];
            end
        end
    end

    always_comb begin
        rd_val = '0;
        if (hit_cmd) begin
            rd_val = {23'b0, err_q, op_code};
        end else if (hit_ham) begin
            rd_val = ham_status;
        end else if (hit_cfg) begin
            rd_val = {16'b0, pw_q};
        end else if (hit_win) begin
            rd_val = mir_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_valid && !bus_write) begin
            rdata_q <= swap32(rd_val);
        end
    end

    assign bus_rdata = rdata_q;
    assign err_flag  = err_q;
    assign pulse_w   = pw_q;

endmodule

// File: rtl/fusectl_seq.sv
module fusectl_seq
    import fusectl_pkg::*;
#(
    parameter int N_WORDS = 34,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_load,
    input  logic             start_burn,
    input  logic [15:0]      pulse_w,
    output logic             busy,
    output logic [7:0]       op_code,
    output logic             cp_en,
    output logic             pg_en,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [15:0]      cnt_q, cnt_d;
    logic [15:0]      cnt_last;
    logic             last_word;

    assign cnt_last  = (pulse_w == 16'd0) ? 16'd0 : (pulse_w - 16'd1);
    assign last_word = (idx_q == LAST_IDX);

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                idx_d = '0;
                cnt_d = '0;
                if (start_load) begin
                    state_d = ST_LOAD;
                end else if (start_burn) begin
                    state_d = ST_BURN;
                end
            end
            ST_LOAD: begin
                if (last_word) begin
                    state_d = ST_IDLE;
                    idx_d   = '0;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            ST_BURN: begin
                if (cnt_q >= cnt_last) begin
                    cnt_d = '0;
                    if (last_word) begin
                        state_d = ST_IDLE;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end else begin
                    cnt_d = cnt_q + 16'd1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                idx_d   = '0;
                cnt_d   = '0;
            end
        endcase
    end

    // State register: reset enters the automatic load.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
            idx_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        busy    = 1'b0;
        op_code = 8'h00;
        cp_en   = 1'b0;
        pg_en   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOAD: begin
                busy    = 1'b1;
                op_code = OP_LOAD;
                cp_en   = 1'b1;
            end
            ST_BURN: begin
                busy    = 1'b1;
                op_code = OP_BURN;
                pg_en   = (cnt_q == 16'd0);
            end
            default: ;
        endcase
    end

    assign idx = idx_q;

endmodule

// File: rtl/fusectl_store.sv
module fusectl_store
    import fusectl_pkg::*;
#(
    parameter int N_WORDS = 34,
    parameter int IDX_W = 6,
    parameter logic [31:0] FACTORY_SEED = 32'h5A3C_9601,
    parameter int SEC_FIRST = 4,
    parameter int SEC_WORDS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cp_en,
    input  logic             pg_en,
    input  logic [IDX_W-1:0] seq_idx,
    input  logic             mir_we,
    input  logic [IDX_W-1:0] bus_idx,
    input  logic [31:0]      mir_wdata,
    output logic [31:0]      mir_rdata,
    output logic [31:0]      ham_status
);

    logic [31:0]          fuse_q   [N_WORDS];
    logic [31:0]          mirror_q [N_WORDS];
    logic [SEC_WORDS-1:0] ham_q;

    // Array and mirror words; array bits can only be set.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_WORDS; i++) begin
                fuse_q[i]   <= factory_word(FACTORY_SEED, i);
                mirror_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N_WORDS; i++) begin
                if (pg_en && (int'(seq_idx) == i)) begin
                    fuse_q[i] <= fuse_q[i] | mirror_q[i];
                end
                if (cp_en && (int'(seq_idx) == i)) begin
                    mirror_q[i] <= fuse_q[i];
                end else if (mir_we && (int'(bus_idx) == i)) begin
                    mirror_q[i] <= mir_wdata;
                end
            end
        end
    end

    // Secret-region parity, refreshed as each secret word is loaded.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ham_q <= '0;
        end else if (cp_en) begin
            for (int k = 0; k < SEC_WORDS; k++) begin
                if (int'(seq_idx) == SEC_FIRST + k) begin
                    ham_q[k] <= ^fuse_q[SEC_FIRST + k];
                end
            end
        end
    end

    always_comb begin
        mir_rdata = '0;
        for (int i = 0; i < N_WORDS; i++) begin
            if (int'(bus_idx) == i) begin
                mir_rdata = mirror_q[i];
            end
        end
    end

    always_comb begin
        ham_status                = '0;
        ham_status[SEC_WORDS-1:0] = ham_q;
    end

endmodule

// File: rtl/fusectl_top.sv
module fusectl_top
    import fusectl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int N_WORDS = 34,
    parameter logic [ADDR_W-1:0] CMD_OFF = 'h20,
    parameter logic [ADDR_W-1:0] HAM_OFF = 'h24,
    parameter logic [ADDR_W-1:0] CFG_OFF = 'h28,
    parameter logic [ADDR_W-1:0] WIN_BASE = 'h200,
    parameter logic [31:0] FACTORY_SEED = 32'h5A3C_9601,
    parameter int SEC_FIRST = 4,
    parameter int SEC_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);

    localparam int IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

    logic             busy;
    logic [7:0]       op_code;
    logic             start_load;
    logic             start_burn;
    logic             err_flag;
    logic [15:0]      pulse_w;
    logic             cp_en;
    logic             pg_en;
    logic [IDX_W-1:0] seq_idx;
    logic             mir_we;
    logic [IDX_W-1:0] mir_idx;
    logic [31:0]      mir_wdata;
    logic [31:0]      mir_rdata;
    logic [31:0]      ham_status;

    fusectl_regs #(
        .ADDR_W  (ADDR_W),
        .N_WORDS (N_WORDS),
        .IDX_W   (IDX_W),
        .CMD_OFF (CMD_OFF),
        .HAM_OFF (HAM_OFF),
        .CFG_OFF (CFG_OFF),
        .WIN_BASE(WIN_BASE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .op_code   (op_code),
        .mir_rdata (mir_rdata),
        .ham_status(ham_status),
        .start_load(start_load),
        .start_burn(start_burn),
        .err_flag  (err_flag),
        .pulse_w   (pulse_w),
        .mir_we    (mir_we),
        .mir_idx   (mir_idx),
        .mir_wdata (mir_wdata)
    );

    fusectl_seq #(
        .N_WORDS(N_WORDS),
        .IDX_W  (IDX_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_load(start_load),
        .start_burn(start_burn),
        .pulse_w   (pulse_w),
        .busy      (busy),
        .op_code   (op_code),
        .cp_en     (cp_en),
        .pg_en     (pg_en),
        .idx       (seq_idx)
    );

    fusectl_store #(
        .N_WORDS     (N_WORDS),
        .IDX_W       (IDX_W),
        .FACTORY_SEED(FACTORY_SEED),
        .SEC_FIRST   (SEC_FIRST),
        .SEC_WORDS   (SEC_WORDS)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .cp_en     (cp_en),
        .pg_en     (pg_en),
        .seq_idx   (seq_idx),
        .mir_we    (mir_we),
        .bus_idx   (mir_idx),
        .mir_wdata (mir_wdata),
        .mir_rdata (mir_rdata),
        .ham_status(ham_status)
    );

endmodule

// File: rtl/fusectl_chk.sv
module fusectl_chk
    import fusectl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int N_WORDS = 34,
    parameter logic [ADDR_W-1:0] CMD_OFF = 'h20,
    parameter logic [ADDR_W-1:0] HAM_OFF = 'h24,
    parameter logic [ADDR_W-1:0] CFG_OFF = 'h28,
    parameter logic [ADDR_W-1:0] WIN_BASE = 'h200
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              busy,
    input logic              start_load,
    input logic              start_burn,
    input logic              err_flag,
    input logic              cp_en,
    input logic              pg_en
);

    logic [7:0] code;
    logic       code_ok;
    logic       cmd_wr;
    logic       in_win;
    logic       mapped;
    logic       rd_cfg;

    assign code    = swap32(bus_wdata) >> 0 == 0 ? 8'h00 : swap32(bus_wdata)[7:0];
    assign code_ok = (code == OP_LOAD) || (code == OP_BURN);
    assign cmd_wr  = bus_valid && bus_write && (bus_addr == CMD_OFF);
    assign in_win  = (int'(bus_addr) >= int'(WIN_BASE)) && (int'(bus_addr) < int'(WIN_BASE) + 4 * N_WORDS)
                     && (bus_addr[1:0] == 2'b00);
    assign mapped  = (bus_addr == CMD_OFF) || (bus_addr == HAM_OFF) || (bus_addr == CFG_OFF) || in_win;
    assign rd_cfg  = bus_valid && !bus_write && (bus_addr == CFG_OFF);

    assert_start_only_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_load || start_burn) |-> !busy);

    assert_busy_write_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> err_flag);

    assert_bad_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy && !code_ok) |=> (err_flag && !busy));

    assert_good_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy && code_ok) |=> (!err_flag && busy));

    assert_err_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |=> $stable(err_flag));

    assert_load_runs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_load |=> cp_en);

    assert_array_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(cp_en || pg_en));

    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && !mapped) |=> (bus_rdata == 32'h0));

    assert_cfg_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cfg |=> (bus_rdata[15:0] == 16'h0));

endmodule

bind fusectl_top fusectl_chk #(
    .ADDR_W  (ADDR_W),
    .N_WORDS (N_WORDS),
    .CMD_OFF (CMD_OFF),
    .HAM_OFF (HAM_OFF),
    .CFG_OFF (CFG_OFF),
    .WIN_BASE(WIN_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy      (busy),
    .start_load(start_load),
    .start_burn(start_burn),
    .err_flag  (err_flag),
    .cp_en     (cp_en),
    .pg_en     (pg_en)
);

// File: tb/fusectl_top_tb.sv
module fusectl_top_tb;

    localparam int          CLK_PERIOD = 10;
    localparam int          N          = 34;
    localparam logic [31:0] SEED       = 32'h5A3C_9601;
    localparam int          SF         = 4;
    localparam int          SW         = 8;
    localparam logic [11:0] A_CMD      = 12'h020;
    localparam logic [11:0] A_HAM      = 12'h024;
    localparam logic [11:0] A_CFG      = 12'h028;
    localparam logic [11:0] A_WIN      = 12'h200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fusectl_top u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_valid(bus_valid),
        .bus_write(bus_write),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] bswap(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic logic [31:0] fac(input int i);
        return SEED ^ (32'(i) * 32'h0101_0107);
    endfunction

    function automatic logic [31:0] pat(input int i);
        return (32'h1 << (i % 32)) | 32'h0010_0000;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        bus_valid = 1'b1;
        bus_write = 1'b1;
        bus_addr  = a;
        bus_wdata = bswap(v);
        @(negedge clk);
        bus_valid = 1'b0;
        bus_write = 1'b0;
    endtask

    task automatic rd_raw(input logic [11:0] a, output logic [31:0] v);
        bus_valid = 1'b1;
        bus_write = 1'b0;
        bus_addr  = a;
        @(negedge clk);
        bus_valid = 1'b0;
        v = bus_rdata;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        logic [31:0] r;
        rd_raw(a, r);
        v = bswap(r);
    endtask

    task automatic poll(output int cnt, output logic [31:0] first_raw, output logic [31:0] last);
        logic [31:0] r;
        cnt = 0;
        first_raw = '0;
        for (int n = 0; n < 20000; n++) begin
            rd_raw(A_CMD, r);
            if (n == 0) first_raw = r;
            last = bswap(r);
            if (last[7:0] == 8'h00) break;
            cnt++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int          cnt;
        logic [31:0] first, last, v, expham;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R2: automatic load after reset
        poll(cnt, first, last);
        chk("R1 reset load busy cycles", 32'(cnt), 32'(N));
        chk("R2 busy code on bus lanes", first, 32'h0100_0000);
        chk("R1 idle command reg", last, 32'h0);
        for (int i = 0; i < N; i++) begin
            rd(A_WIN + 12'(4 * i), v);
            chk($sformatf("R1 mirror %0d after reset", i), v, fac(i));
        end
        expham = '0;
        for (int k = 0; k < SW; k++) expham[k] = ^fac(SF + k);
        rd(A_HAM, v);
        chk("R10 status after reset", v, expham);

        // R6: config register
        wr(A_CFG, 32'hABCD_1234);
        rd(A_CFG, v);
        chk("R6 config readback", v, 32'h0000_1234);

        // R11: unmapped and misaligned
        wr(12'h030, 32'hFFFF_FFFF);
        rd(12'h030, v);
        chk("R11 unmapped 0x030", v, 32'h0);
        rd(12'h288, v);
        chk("R11 beyond window", v, 32'h0);
        rd(12'h202, v);
        chk("R11 misaligned", v, 32'h0);
        wr(12'h201, 32'hDEAD_BEEF);
        rd(A_WIN, v);
        chk("R11 misaligned write ignored", v, fac(0));
        wr(A_HAM, 32'hFFFF_FFFF);
        rd(A_HAM, v);
        chk("R10 status ignores writes", v, expham);

        // R5 / R3: override then reload
        wr(A_WIN + 12'd12, 32'h1234_5678);
        rd(A_WIN + 12'd12, v);
        chk("R5 mirror override", v, 32'h1234_5678);
        wr(A_CMD, 32'h1);
        poll(cnt, first, last);
        chk("R3 load busy cycles", 32'(cnt), 32'(N));
        chk("R3 instruction field", bswap(first), 32'h1);
        rd(A_WIN + 12'd12, v);
        chk("R5 reload restores word 3", v, fac(3));

        // R7 / R9: unknown code, then valid code clears
        wr(A_WIN + 12'd8, 32'h0BAD_0BAD);
        wr(A_CMD, 32'h7);
        rd(A_CMD, v);
        chk("R7 error flag set", v, 32'h100);
        rd(A_WIN + 12'd8, v);
        chk("R7 nothing started", v, 32'h0BAD_0BAD);
        wr(A_CMD, 32'h1);
        poll(cnt, first, last);
        chk("R9 error cleared by valid code", last, 32'h0);

        // R4: burn with pulse width 3
        wr(A_CFG, 32'h3);
        for (int i = 0; i < N; i++) wr(A_WIN + 12'(4 * i), pat(i));
        wr(A_CMD, 32'h2);
        poll(cnt, first, last);
        chk("R4 burn busy cycles pw3", 32'(cnt), 32'(N * 3));
        chk("R4 burn code", bswap(first), 32'h2);
        wr(A_CMD, 32'h1);
        poll(cnt, first, last);
        for (int i = 0; i < N; i++) begin
            rd(A_WIN + 12'(4 * i), v);
            chk($sformatf("R4 array word %0d ORed", i), v, fac(i) | pat(i));
        end
        expham = '0;
        for (int k = 0; k < SW; k++) expham[k] = ^(fac(SF + k) | pat(SF + k));
        rd(A_HAM, v);
        chk("R10 status after burn", v, expham);

        // R8: command write during a running burn
        wr(A_CFG, 32'h2);
        wr(A_CMD, 32'h2);
        rd(A_CMD, v);
        chk("R8 busy before extra write", v, 32'h2);
        wr(A_CMD, 32'h1);
        poll(cnt, first, last);
        chk("R8 duration unchanged", 32'(cnt), 32'(N * 2 - 2));
        chk("R8 error flag after busy write", last, 32'h100);

        // R4 boundary: pulse width 0 behaves as 1
        wr(A_CFG, 32'h0);
        wr(A_CMD, 32'h2);
        poll(cnt, first, last);
        chk("R4 burn busy cycles pw0", 32'(cnt), 32'(N));
        chk("R9 error cleared by burn", last, 32'h0);
        wr(A_CMD, 32'h1);
        poll(cnt, first, last);
        rd(A_WIN + 12'(4 * (N - 1)), v);
        chk("R4 last word stable after reburn", v, fac(N - 1) | pat(N - 1));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule